// File: doc/BRIEF.md
# SDRAM Command Mode Sequencer

This block lets software bring up and maintain SDR SDRAM devices one command at a time. Software first programs a timing word and then writes a command word. The command word selects an operating mode, one or both target devices, a repeat count for auto-refresh, and a value to load into the device mode register. The block then drives the SDRAM control pins to carry out the command. It inserts the programmed idle gaps after each command. A status bit stays high until the whole command has finished.

Software polls the status bit and writes the next command only after the bit reads zero. A typical bring-up runs in this order:
1. Enable the clock.
2. Wait at least 200 us.
3. Precharge all banks.
4. Issue eight auto-refreshes.
5. Load the mode register.
6. Return to normal mode.

The block orders none of these steps by itself. Software sequences every step.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, CKE is 0. The pins show NOP: both chip selects high, RAS#, CAS# and WE# high, and address and bank zero. The busy status is 0.
- R2: A write to register 1 while busy is 0 is accepted, and busy reads 1 from the next cycle. While busy is 1, writes to register 1 and register 0 are ignored. This includes a write in the last busy cycle.
- R3: The mode sits in command bits 2:0. The codes are 0 normal, 1 clock enable, 2 precharge all, 3 auto-refresh and 4 load mode register. Codes 5, 6 and 7 issue no command. Modes 0, 1, 5, 6 and 7 keep the pins at NOP and hold busy for exactly one cycle.
- R4: Clock-enable mode raises CKE in the cycle after acceptance. No later command lowers CKE.
- R5: Command bit 4 selects device 1 and drives chip select 0 low during a command. Command bit 3 selects device 2 and drives chip select 1 low. A device whose bit is clear stays deselected, but the timing still runs.
- R6: Precharge all drives RAS#=0, CAS#=1 and WE#=0 with A10 high and all other address bits zero. It then holds tRP+1 NOP cycles with busy high before busy clears.
- R7: Auto-refresh drives RAS#=0, CAS#=0 and WE#=1. Command bits 8:5 hold the refresh count minus one. Consecutive refreshes start tRC+2 cycles apart. Busy clears after tRC+1 NOP cycles that follow the last refresh.
- R8: Load mode register drives RAS#=0, CAS#=0 and WE#=0 with bank zero. The address pins carry command bits starting at bit 9, so burst length lands on A2:A0 and CAS latency on A6:A4. It then holds tMRD+1 NOP cycles before busy clears.
- R9: Register 0 holds the timing fields, each 4 bits wide and holding cycles minus one:
  - bits 3:0: tMRD
  - bits 15:12: tRC
  - bits 23:20: tRP
  - The other nibbles up to bit 27 are stored but unused.
- R10: Register reads are combinational. Address 0 returns the timing word with bits 31:28 zero. Address 1 returns the last accepted command word. Address 2 returns busy at bit 5 and zeros elsewhere. Address 3 returns zero.
- R11: Every command lasts exactly one cycle on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 timing, 1 command, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 2 | Chip selects, bit 0 device 1, bit 1 device 2 |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable strobe |
| sd_addr | output | ADDR_W | SDRAM address pins |
| sd_ba | output | BA_W | SDRAM bank pins |

## Verification
The risky coincidence is a new command write that arrives in the same cycle that busy is about to clear. At that clock edge the sequencer either finishes or issues its next refresh. The bench provokes this in two ways:
- It writes commands on consecutive cycles, so the second write lands in a one-cycle busy window and the third lands on the first free cycle.
- It also writes during a gap that ends a refresh train.

A behavioural model judges each case. The model drops any write seen while its own expected busy is 1 at that edge, and accepts the write otherwise. The bench then compares the pins and register reads against the model on every cycle.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sd_cke,
  output logic [1:0]        sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba
);

  localparam logic [1:0] A_TIM = 2'd0;
  localparam logic [1:0] A_CMD = 2'd1;
  localparam logic [1:0] A_STS = 2'd2;
  localparam int BUSY_BIT = 5;
  localparam int MR_LSB   = 9;
  localparam int CNT_W    = 5;

  typedef enum logic [2:0] {
    M_NORM = 3'd0, M_CKE = 3'd1, M_PRE = 3'd2, M_REF = 3'd3, M_LMR = 3'd4
  } mode_e;

  logic [27:0]       tim_q;
  logic [31:0]       cmd_q;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [3:0]        rem_q;
  logic              cke_q, ras_q, cas_q, we_q;
  logic [1:0]        cs_q;
  logic [ADDR_W-1:0] addr_q;

  wire wr_cmd = reg_we && reg_addr == A_CMD && !busy_q;
  wire wr_tim = reg_we && reg_addr == A_TIM && !busy_q;

  wire [2:0] wr_mode = reg_wdata[2:0];
  wire [1:0] wr_sel  = {~reg_wdata[3], ~reg_wdata[4]};
  wire [1:0] q_sel   = {~cmd_q[3], ~cmd_q[4]};

  wire [CNT_W-1:0] gap_mrd = {1'b0, tim_q[3:0]}   + 1'b1;
  wire [CNT_W-1:0] gap_rc  = {1'b0, tim_q[15:12]} + 1'b1;
  wire [CNT_W-1:0] gap_rp  = {1'b0, tim_q[23:20]} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q  <= '0;
      cmd_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      cke_q  <= 1'b0;
      cs_q   <= 2'b11;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      cs_q   <= 2'b11;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
      addr_q <= '0;
      if (wr_tim) tim_q <= reg_wdata[27:0];
      if (wr_cmd) begin
        cmd_q  <= reg_wdata;
        busy_q <= 1'b1;
        rem_q  <= reg_wdata[8:5];
        cnt_q  <= '0;
        case (wr_mode)
          M_CKE: cke_q <= 1'b1;
          M_PRE: begin
            cs_q       <= wr_sel;
            ras_q      <= 1'b0;
            we_q       <= 1'b0;
            addr_q[10] <= 1'b1;
            cnt_q      <= gap_rp;
          end
          M_REF: begin
            cs_q  <= wr_sel;
            ras_q <= 1'b0;
            cas_q <= 1'b0;
            cnt_q <= gap_rc;
          end
          M_LMR: begin
            cs_q   <= wr_sel;
            ras_q  <= 1'b0;
            cas_q  <= 1'b0;
            we_q   <= 1'b0;
            addr_q <= reg_wdata[MR_LSB +: ADDR_W];
            cnt_q  <= gap_mrd;
          end
          default: ;
        endcase
      end else if (busy_q) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (cmd_q[2:0] == M_REF && rem_q != '0) begin
          cs_q  <= q_sel;
          ras_q <= 1'b0;
          cas_q <= 1'b0;
          rem_q <= rem_q - 1'b1;
          cnt_q <= gap_rc;
        end else begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_TIM:   reg_rdata = {4'b0, tim_q};
      A_CMD:   reg_rdata = cmd_q;
      A_STS:   reg_rdata = 32'(busy_q) << BUSY_BIT;
      default: reg_rdata = '0;
    endcase
  end

  assign sd_cke   = cke_q;
  assign sd_cs_n  = cs_q;
  assign sd_ras_n = ras_q;
  assign sd_cas_n = cas_q;
  assign sd_we_n  = we_q;
  assign sd_addr  = addr_q;
  assign sd_ba    = '0;

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CMD && !busy_q) |=> busy_q);

  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CMD && busy_q) |=> $stable(cmd_q));

  // R3
  short_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CMD && !busy_q &&
     (reg_wdata[2:0] == 3'd0 || reg_wdata[2:0] == 3'd1 || reg_wdata[2:0] > 3'd4))
    |=> (busy_q ##1 !busy_q));

  // R4
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sd_cke));

  // R11
  single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_ras_n |=> sd_ras_n);

  // R6
  pre_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[10]);

  // R5
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (sd_cs_n == 2'b11 && sd_ras_n && sd_cas_n && sd_we_n));

endmodule

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;
  localparam int PERIOD = 10;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic sd_cke, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_cs_n;
  logic [AW-1:0] sd_addr;
  logic [1:0] sd_ba;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  sdram_cmd_seq #(.ADDR_W(AW), .BA_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba));

  typedef struct {
    logic busy;
    logic [1:0] cs;
    logic ras, cas, we;
    logic [AW-1:0] addr;
  } cyc_t;

  cyc_t q[$];
  cyc_t cur;
  logic m_cke;
  logic [27:0] m_tim;
  logic [31:0] m_last;

  function automatic cyc_t idle_cyc(input logic b);
    cyc_t c;
    c.busy = b; c.cs = 2'b11; c.ras = 1'b1; c.cas = 1'b1; c.we = 1'b1; c.addr = '0;
    return c;
  endfunction

  task automatic push_cmd(input logic [1:0] cs, input logic r, input logic c,
                          input logic w, input logic [AW-1:0] a, input int gap);
    cyc_t e;
    e.busy = 1'b1; e.cs = cs; e.ras = r; e.cas = c; e.we = w; e.addr = a;
    q.push_back(e);
    for (int i = 0; i < gap + 1; i++) q.push_back(idle_cyc(1'b1));
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = idle_cyc(1'b0);
      m_cke = 1'b0;
      m_tim = '0;
      m_last = '0;
    end else begin
      if (!cur.busy && reg_we && reg_addr == 2'd0) m_tim = reg_wdata[27:0];
      if (!cur.busy && reg_we && reg_addr == 2'd1) begin
        logic [1:0] sel;
        int md;
        sel = {~reg_wdata[3], ~reg_wdata[4]};
        md = int'(reg_wdata[2:0]);
        m_last = reg_wdata;
        if (md == 2) begin
          logic [AW-1:0] a10;
          a10 = '0; a10[10] = 1'b1;
          push_cmd(sel, 1'b0, 1'b1, 1'b0, a10, int'(m_tim[23:20]));
        end else if (md == 3) begin
          for (int k = 0; k <= int'(reg_wdata[8:5]); k++)
            push_cmd(sel, 1'b0, 1'b0, 1'b1, '0, int'(m_tim[15:12]));
        end else if (md == 4) begin
          push_cmd(sel, 1'b0, 1'b0, 1'b0, reg_wdata[9 +: AW], int'(m_tim[3:0]));
        end else begin
          if (md == 1) m_cke = 1'b1;
          q.push_back(idle_cyc(1'b1));
        end
      end
      if (q.size() > 0) cur = q.pop_front();
      else cur = idle_cyc(1'b0);
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] er;
    case (reg_addr)
      2'd0: er = {4'b0, m_tim};
      2'd1: er = m_last;
      2'd2: er = 32'(cur.busy) << 5;
      default: er = '0;
    endcase
    chk("R4 cke", longint'(sd_cke), longint'(m_cke));
    chk("R5 chip selects", longint'(sd_cs_n), longint'(cur.cs));
    chk("R11 ras/cas/we", longint'({sd_ras_n, sd_cas_n, sd_we_n}),
        longint'({cur.ras, cur.cas, cur.we}));
    chk("R8 addr/bank", longint'({sd_ba, sd_addr}), longint'({2'b00, cur.addr}));
    chk("R10 read data", longint'(reg_rdata), longint'(er));
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic wait_idle();
    reg_addr = 2'd2;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (reg_rdata[5] == 1'b0) break;
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    tick(3);
    // R1: reset state checked every cycle by the model
    rst_n = 1'b1;
    tick(2);
    // R9 R10: timing layout, upper bits dropped on readback
    wr(2'd0, 32'hF3245671);
    reg_addr = 2'd0; tick(1);
    // R3 R4: clock enable on device 1
    wr(2'd1, 32'h0000_0011);
    wait_idle();
    tick(20);
    // R6: precharge all on device 1, tRP=2
    wr(2'd1, 32'h0000_0012);
    wait_idle();
    // R7: eight refreshes, write in the middle is ignored (R2)
    wr(2'd1, 32'h0000_00F3);
    wr(2'd1, 32'h0000_0014);
    tick(3);
    wr(2'd0, 32'h0000_0000);
    wait_idle();
    reg_addr = 2'd1; tick(1);
    reg_addr = 2'd0; tick(1);
    // R8: load mode register, CL3 BL0
    wr(2'd1, (32'h30 << 9) | 32'h14);
    wait_idle();
    // R3: normal mode
    wr(2'd1, 32'h0000_0010);
    wait_idle();
    // R5: both devices, then no device
    wr(2'd1, 32'h0000_001A);
    wait_idle();
    wr(2'd1, 32'h0000_0023);
    wait_idle();
    // R5: device 2 only, timing write while busy ignored (R2)
    wr(2'd1, 32'h0000_000A);
    wr(2'd0, 32'h0000_0000);
    wait_idle();
    wr(2'd1, 32'h0000_000A);
    wait_idle();
    // R2: back-to-back writes around a one-cycle busy window
    wr(2'd1, 32'h0000_0010);
    wr(2'd1, 32'h0000_0012);
    wr(2'd1, 32'h0000_000B);
    wait_idle();
    // R2: write on the last busy cycle of a refresh train
    wr(2'd1, 32'h0000_0033);
    tick(2 * 7 - 1);
    wr(2'd1, 32'h0000_0012);
    wr(2'd1, 32'h0000_0014);
    wait_idle();
    // R3: codes 5, 6, 7 issue nothing
    wr(2'd1, 32'h0000_0015);
    wr(2'd1, 32'h0000_0016);
    wr(2'd1, 32'h0000_0016);
    wr(2'd1, 32'h0000_0017);
    wait_idle();
    // R8: all mode-register bits set
    wr(2'd1, (32'h1FFF << 9) | 32'h1C);
    wait_idle();
    // R7 R9: maximum timings, sixteen refreshes
    wr(2'd0, 32'h0FFF_FFFF);
    wr(2'd1, 32'h0000_01F3);
    wait_idle();
    wr(2'd1, 32'h0000_0012);
    wait_idle();
    reg_addr = 2'd3; tick(2);
    reg_addr = 2'd2; tick(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL R2 watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule